// File: doc/BRIEF.md
# VLAN Group Classifier with Egress Port Filter

This block watches the receive byte stream of a five-port Ethernet switch and decides, for every frame, which of five VLAN groups the frame belongs to, which priority class it carries and which ports it may leave on. Bytes arrive one per accepted cycle, with a start-of-frame marker on the first byte and the number of the port the frame came in on. The block only reads as far as the VLAN tag control field; every byte after that is ignored until the next start of frame.

A frame carrying the 802.1Q type value gets its group from the 12-bit VLAN identifier, by comparing it against five programmable identifier registers. An untagged frame, or a tagged frame whose identifier is zero, takes the group programmed as the default for its ingress port. The egress mask is the member set of the chosen group with the ingress port cleared. A tagged frame that names an unknown or reserved identifier is marked for drop with an empty mask. Groups are numbered 0 to 4, and a small write port loads the per-port defaults, the identifiers and the member sets.

Top module: `vlan_sort`

## Requirements
- R1: After reset, port n's default group is n, all five identifier registers are 0x000, and the member masks (bit n = port n) are 5'b10001, 5'b10010, 5'b10100, 5'b11000 and 5'b11111 for groups 0 to 4.
- R2: A frame is untagged unless byte 12 is 0x81 and byte 13 is 0x00 (byte 0 is the byte accepted with `in_sof`). An untagged frame raises `res_valid` in the cycle after byte 13 is accepted, with `res_group` equal to its ingress port's default group and `res_hipri` 0.
- R3: A tagged frame raises `res_valid` in the cycle after byte 15 is accepted, and never after byte 13.
- R4: For a tagged frame, `res_hipri` is 1 exactly when the priority field, bits 7:5 of byte 14, is 4 or more.
- R5: The identifier of a tagged frame is {byte 14 bits 3:0, byte 15}. A nonzero identifier other than 0xFFF selects the lowest-numbered group whose identifier register equals it.
- R6: A tagged frame with identifier 0x000 takes its ingress port's default group, while `res_hipri` still follows its priority field.
- R7: A tagged frame with identifier 0xFFF, or one that no register matches, gives `res_drop`=1, `res_mask`=0 and `res_group`=7.
- R8: When not dropped, `res_mask` is the chosen group's member mask with the ingress port's bit cleared.
- R9: A write with `cfg_we`=1 loads `cfg_data[2:0]` into port p's default group for `cfg_sel`=p (0 to 4), `cfg_data[11:0]` into group g's identifier for `cfg_sel`=5+g, and `cfg_data[4:0]` into group g's member mask for `cfg_sel`=10+g. `cfg_sel`=15 changes nothing.
- R10: A frame that falls back to a port default of 5, 6 or 7 gives `res_drop`=1, `res_mask`=0 and `res_group`=7.
- R11: Each frame raises `res_valid` for exactly one cycle. Bytes with `in_valid` low, including a start marker with `in_valid` low, are ignored. `in_port` is sampled only with the start byte. Bytes after the deciding byte are ignored. A new start byte restarts parsing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_sof | input | 1 | Accepted byte is byte 0 of a new frame |
| in_byte | input | 8 | Frame byte |
| in_port | input | 3 | Ingress port number, taken with the start byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_data | input | 12 | Configuration write value |
| res_valid | output | 1 | One-cycle result strobe |
| res_group | output | 3 | Group 0 to 4, or 7 when dropped |
| res_hipri | output | 1 | High priority class |
| res_drop | output | 1 | Frame must be discarded |
| res_mask | output | 5 | Allowed egress ports |

## Verification
If the byte position counter slips, a tagged frame looks untagged, or the other way round, and the result strobe shows up two cycles early or late. The bench samples exactly one cycle after the deciding byte, so it sees this on the very first frame. A wrong identifier match, a wrong default table or a wrong member table shows up in `res_group` or `res_mask` on the same strobe. A sweep over every port, every priority value and a set of identifiers reaches each table entry several times. A stale frame-active flag shows up as a second strobe from the trailing bytes, which the bench counts for each frame.

// File: rtl/vlan_sort_pkg.sv
package vlan_sort_pkg;
  localparam int N_PORT = 5;
  localparam int N_GRP  = 5;
  localparam int IDX_W  = 3;
  localparam int VID_W  = 12;
  localparam int PRI_W  = 3;
  localparam int BYTE_W = 8;
  localparam int POS_W  = 5;
  localparam int SEL_W  = 4;

  localparam int POS_TPID_HI = 12;
  localparam int POS_TPID_LO = 13;
  localparam int POS_TCI_HI  = 14;
  localparam int POS_TCI_LO  = 15;

  localparam int SEL_IDX_BASE = 0;
  localparam int SEL_VID_BASE = N_PORT;
  localparam int SEL_MEM_BASE = N_PORT + N_GRP;

  localparam logic [BYTE_W-1:0] TPID_HI = 8'h81;
  localparam logic [BYTE_W-1:0] TPID_LO = 8'h00;

  typedef logic [N_PORT-1:0] pmask_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [VID_W-1:0]  vid_t;

  localparam vid_t VID_PRIO = '0;
  localparam vid_t VID_RSVD = '1;
  localparam idx_t GRP_NONE = '1;

  function automatic pmask_t default_member(input int g);
    pmask_t m;
    m = '0;
    if (g == N_GRP - 1) begin
      m = '1;
    end else begin
      m[N_PORT-1] = 1'b1;
      m[g]        = 1'b1;
    end
    return m;
  endfunction

  function automatic idx_t default_index(input int p);
    return idx_t'(p);
  endfunction

  function automatic logic is_tpid(input logic [BYTE_W-1:0] hi, input logic [BYTE_W-1:0] lo);
    return (hi == TPID_HI) && (lo == TPID_LO);
  endfunction

  function automatic pmask_t strip_port(input pmask_t m, input idx_t p);
    pmask_t one;
    one = pmask_t'(1);
    return m & ~(one << p);
  endfunction

  function automatic logic high_class(input logic [PRI_W-1:0] pri);
    return pri[PRI_W-1];
  endfunction
endpackage

// File: rtl/vs_parse.sv
module vs_parse
  import vlan_sort_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [BYTE_W-1:0] in_byte,
  input  idx_t              in_port,
  output logic              ev_untag,
  output logic              ev_tag,
  output idx_t              cap_port,
  output logic [PRI_W-1:0]  tag_pri,
  output vid_t              tag_vid
);
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  cur_pos;
  logic              busy_q;
  logic              take;
  logic [BYTE_W-1:0] tpid_hi_q;
  logic [BYTE_W-1:0] tci_hi_q;
  idx_t              port_q;

  assign cur_pos = in_sof ? '0 : pos_q;
  assign take    = in_valid && (in_sof || busy_q);

  assign ev_untag = take && (cur_pos == POS_W'(POS_TPID_LO)) && !is_tpid(tpid_hi_q, in_byte);
  assign ev_tag   = take && (cur_pos == POS_W'(POS_TCI_LO));

  assign cap_port = port_q;
  assign tag_pri  = tci_hi_q[BYTE_W-1 -: PRI_W];
  assign tag_vid  = {tci_hi_q[VID_W-BYTE_W-1:0], in_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      busy_q    <= 1'b0;
      tpid_hi_q <= '0;
      tci_hi_q  <= '0;
      port_q    <= '0;
    end else if (take) begin
      pos_q <= cur_pos + POS_W'(1);
      if (in_sof) begin
        busy_q <= 1'b1;
        port_q <= in_port;
      end
      if (cur_pos == POS_W'(POS_TPID_HI)) tpid_hi_q <= in_byte;
      if (cur_pos == POS_W'(POS_TCI_HI))  tci_hi_q  <= in_byte;
      if (ev_untag || ev_tag) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/vs_cfg.sv
module vs_cfg
  import vlan_sort_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  vid_t                   cfg_data,
  output idx_t   [N_PORT-1:0]    port_idx,
  output vid_t   [N_GRP-1:0]     grp_vid,
  output pmask_t [N_GRP-1:0]     grp_mem
);
  for (genvar p = 0; p < N_PORT; p++) begin : g_idx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) port_idx[p] <= default_index(p);
      else if (cfg_we && cfg_sel == SEL_W'(SEL_IDX_BASE + p)) port_idx[p] <= cfg_data[IDX_W-1:0];
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        grp_vid[g] <= VID_PRIO;
        grp_mem[g] <= default_member(g);
      end else if (cfg_we) begin
        if (cfg_sel == SEL_W'(SEL_VID_BASE + g)) grp_vid[g] <= cfg_data;
        if (cfg_sel == SEL_W'(SEL_MEM_BASE + g)) grp_mem[g] <= cfg_data[N_PORT-1:0];
      end
    end
  end
endmodule

// File: rtl/vs_decide.sv
module vs_decide
  import vlan_sort_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_untag,
  input  logic                   ev_tag,
  input  idx_t                   cap_port,
  input  logic [PRI_W-1:0]       tag_pri,
  input  vid_t                   tag_vid,
  input  idx_t   [N_PORT-1:0]    port_idx,
  input  vid_t   [N_GRP-1:0]     grp_vid,
  input  pmask_t [N_GRP-1:0]     grp_mem,
  output logic                   res_valid,
  output idx_t                   res_group,
  output logic                   res_hipri,
  output logic                   res_drop,
  output pmask_t                 res_mask
);
  logic [N_GRP-1:0] vid_hit;
  logic             hit_any;
  idx_t             hit_grp;
  logic             use_port;
  logic             port_ok;
  idx_t             base_grp;
  logic             grp_ok;
  logic             drop_now;
  pmask_t           sel_mem;
  logic             fire;

  for (genvar g = 0; g < N_GRP; g++) begin : g_cmp
    assign vid_hit[g] = (grp_vid[g] == tag_vid);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_grp = GRP_NONE;
    for (int g = N_GRP - 1; g >= 0; g--) begin
      if (vid_hit[g]) begin
        hit_any = 1'b1;
        hit_grp = idx_t'(g);
      end
    end
  end

  assign fire     = ev_untag || ev_tag;
  assign use_port = ev_untag || (tag_vid == VID_PRIO);
  assign port_ok  = int'(cap_port) < N_PORT;
  assign base_grp = use_port ? (port_ok ? port_idx[cap_port] : GRP_NONE) : hit_grp;
  assign grp_ok   = int'(base_grp) < N_GRP;
  assign drop_now = use_port ? !grp_ok : ((tag_vid == VID_RSVD) || !hit_any);
  assign sel_mem  = grp_ok ? grp_mem[base_grp] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_group <= '0;
      res_hipri <= 1'b0;
      res_drop  <= 1'b0;
      res_mask  <= '0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_group <= drop_now ? GRP_NONE : base_grp;
        res_hipri <= ev_tag && high_class(tag_pri);
        res_drop  <= drop_now;
        res_mask  <= drop_now ? '0 : strip_port(sel_mem, cap_port);
      end
    end
  end
endmodule

// File: rtl/vlan_sort.sv
module vlan_sort (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic [7:0]  in_byte,
  input  logic [2:0]  in_port,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_sel,
  input  logic [11:0] cfg_data,
  output logic        res_valid,
  output logic [2:0]  res_group,
  output logic        res_hipri,
  output logic        res_drop,
  output logic [4:0]  res_mask
);
  import vlan_sort_pkg::*;

  logic                ev_untag;
  logic                ev_tag;
  idx_t                cap_port;
  logic [PRI_W-1:0]    tag_pri;
  vid_t                tag_vid;
  idx_t   [N_PORT-1:0] port_idx;
  vid_t   [N_GRP-1:0]  grp_vid;
  pmask_t [N_GRP-1:0]  grp_mem;

  vs_parse u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_byte(in_byte), .in_port(in_port), .ev_untag(ev_untag), .ev_tag(ev_tag),
    .cap_port(cap_port), .tag_pri(tag_pri), .tag_vid(tag_vid)
  );

  vs_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .port_idx(port_idx), .grp_vid(grp_vid), .grp_mem(grp_mem)
  );

  vs_decide u_decide (
    .clk(clk), .rst_n(rst_n), .ev_untag(ev_untag), .ev_tag(ev_tag),
    .cap_port(cap_port), .tag_pri(tag_pri), .tag_vid(tag_vid),
    .port_idx(port_idx), .grp_vid(grp_vid), .grp_mem(grp_mem),
    .res_valid(res_valid), .res_group(res_group), .res_hipri(res_hipri),
    .res_drop(res_drop), .res_mask(res_mask)
  );
endmodule

// File: rtl/vs_check.sv
module vs_check
  import vlan_sort_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   ev_untag,
  input logic   ev_tag,
  input idx_t   cap_port,
  input logic   res_valid,
  input idx_t   res_group,
  input logic   res_hipri,
  input logic   res_drop,
  input pmask_t res_mask
);
  localparam pmask_t ONE = pmask_t'(1);

  // R2 / R3: a frame is decided either at byte 13 or at byte 15, never both
  p_single_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_untag && ev_tag));

  p_strobe_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_untag || ev_tag) |=> res_valid);

  p_strobe_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_untag || ev_tag) |=> !res_valid);

  p_untagged_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_untag |=> !res_hipri);

  p_drop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_drop) |-> (res_mask == '0 && res_group == GRP_NONE));

  p_group_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_drop) |-> (int'(res_group) < N_GRP));

  p_no_hairpin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_untag || ev_tag) |=> ((res_mask & (ONE << $past(cap_port))) == '0));
endmodule

bind vlan_sort vs_check u_check (
  .clk(clk), .rst_n(rst_n), .ev_untag(ev_untag), .ev_tag(ev_tag),
  .cap_port(cap_port), .res_valid(res_valid), .res_group(res_group),
  .res_hipri(res_hipri), .res_drop(res_drop), .res_mask(res_mask)
);

// File: tb/test_vlan_sort.sv
module test_vlan_sort;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [2:0]  in_port = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [11:0] cfg_data = '0;
  logic        res_valid;
  logic [2:0]  res_group;
  logic        res_hipri;
  logic        res_drop;
  logic [4:0]  res_mask;

  int n_chk = 0;
  int n_err = 0;
  int pulses = 0;
  int m_idx[5];
  int m_vid[5];
  int m_mem[5];
  bit done = 0;

  always #5 clk = ~clk;

  vlan_sort i_vlan_sort (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_byte(in_byte),
    .in_port(in_port), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .res_valid(res_valid), .res_group(res_group), .res_hipri(res_hipri),
    .res_drop(res_drop), .res_mask(res_mask)
  );

  always @(negedge clk) if (res_valid) pulses++;

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cfg_write(input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_data = 12'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 5)       m_idx[sel]    = data & 7;
    else if (sel < 10) m_vid[sel-5]  = data & 12'hFFF;
    else if (sel < 15) m_mem[sel-10] = data & 5'h1F;
  endtask

  // independent model of the classification requirements
  task automatic expect_of(input int port, input bit tag, input int b14, input int b15,
                           output int grp, output int hi, output int drp, output int msk);
    int vid;
    vid = ((b14 & 15) << 8) | b15;
    hi  = tag ? ((b14 >> 5) >= 4) : 0;
    grp = 7;
    if (tag && vid != 0) begin
      if (vid != 12'hFFF)
        for (int g = 4; g >= 0; g--) if (m_vid[g] == vid) grp = g;
    end else begin
      grp = (m_idx[port] < 5) ? m_idx[port] : 7;
    end
    drp = (grp == 7);
    msk = drp ? 0 : (m_mem[grp] & ~(1 << port) & 5'h1F);
  endtask

  task automatic send_frame(input string rq, input int port, input int b12, input int b13,
                            input int b14, input int b15, input bit bubble);
    bit tag;
    int dec, grp, hi, drp, msk, bv;
    tag = (b12 == 8'h81) && (b13 == 8'h00);
    dec = tag ? 15 : 13;
    expect_of(port, tag, b14, b15, grp, hi, drp, msk);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == dec + 1) begin
        chk({rq, " strobe"}, int'(res_valid), 1);
        chk({rq, " group"},  int'(res_group), grp);
        chk({rq, " R4 class"}, int'(res_hipri), hi);
        chk({rq, " R7 drop"}, int'(res_drop), drp);
        chk({rq, " R8 mask"}, int'(res_mask), msk);
      end
      if (bubble && i == 5) begin
        in_valid = 1'b0; in_sof = 1'b1; in_byte = 8'h81;
        @(negedge clk);
      end
      case (i)
        12: bv = b12;
        13: bv = b13;
        14: bv = b14;
        15: bv = b15;
        default: bv = (i * 37 + 5) & 8'hFF;
      endcase
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_byte  = 8'(bv);
      in_port  = (i == 0) ? 3'(port) : 3'((port + 1) % 5);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    @(negedge clk);
    chk({rq, " R11 one strobe per frame"}, pulses, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int vids[8];
    for (int k = 0; k < 5; k++) begin
      m_idx[k] = k;
      m_vid[k] = 0;
      m_mem[k] = (k == 4) ? 5'h1F : ((1 << 4) | (1 << k));
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset strobe low", int'(res_valid), 0);
    chk("R1 reset mask", int'(res_mask), 0);

    // R1: default tables seen through untagged frames from each port
    for (int p = 0; p < 5; p++) send_frame("R1 R2 default untagged", p, 8'h08, 8'h00, 8'hE5, 8'h01, 0);
    // R1: with all identifier registers zero, any tagged nonzero id is dropped
    send_frame("R1 R7 unset identifiers", 2, 8'h81, 8'h00, 8'h00, 8'h01, 0);
    // R2 / R3: near-miss type values are untagged
    send_frame("R2 R3 wrong low type byte", 1, 8'h81, 8'h01, 8'hE0, 8'h05, 0);
    send_frame("R2 R3 wrong high type byte", 3, 8'h88, 8'h00, 8'hE0, 8'h05, 1);

    // R9: program identifiers and check through tagged traffic
    cfg_write(5, 12'h001);
    cfg_write(6, 12'h002);
    cfg_write(7, 12'h123);
    cfg_write(8, 12'hABC);
    cfg_write(9, 12'hFFE);
    vids = '{12'h000, 12'h001, 12'h002, 12'h123, 12'hABC, 12'hFFE, 12'hFFF, 12'h777};
    for (int p = 0; p < 5; p++)
      for (int pr = 0; pr < 8; pr++)
        for (int v = 0; v < 8; v++)
          send_frame("R3 R4 R5 R6 R7 R9 sweep", p, 8'h81, 8'h00,
                     (pr << 5) | (((pr + v) & 1) << 4) | ((vids[v] >> 8) & 15),
                     vids[v] & 8'hFF, (v == 3));

    // R5: duplicated identifier resolves to the lower group
    cfg_write(8, 12'h002);
    send_frame("R5 lowest group wins", 0, 8'h81, 8'h00, 8'h60, 8'h02, 0);
    // R7: a register holding the reserved id never matches
    cfg_write(9, 12'hFFF);
    send_frame("R7 reserved id with matching register", 3, 8'h81, 8'h00, 8'h8F, 8'hFF, 0);

    // R9 / R10: new port defaults and member sets
    cfg_write(2, 6);
    cfg_write(3, 1);
    cfg_write(11, 5'b01111);
    send_frame("R10 default out of range", 2, 8'h00, 8'h00, 8'h00, 8'h00, 0);
    send_frame("R10 priority tag out of range", 2, 8'h81, 8'h00, 8'hA0, 8'h00, 0);
    send_frame("R6 R9 remapped port", 3, 8'h81, 8'h00, 8'hE0, 8'h00, 0);
    send_frame("R2 R8 R9 new member set", 3, 8'h45, 8'h67, 8'hE0, 8'h00, 0);
    send_frame("R8 R9 tagged new member set", 4, 8'h81, 8'h00, 8'h40, 8'h02, 0);

    // R9: select 15 is not a register
    cfg_write(15, 12'hFFF);
    for (int p = 0; p < 5; p++) send_frame("R9 select 15 ignored", p, 8'h00, 8'h00, 8'h00, 8'h00, 0);

    // R11: aborted frame then restart
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_byte = (i == 6) ? 8'h81 : 8'h00; in_port = 3'd1;
    end
    send_frame("R11 restart after abort", 0, 8'h81, 8'h00, 8'h20, 8'h01, 0);

    finish_run();
  end
endmodule